// File: doc/BRIEF.md
# Multithreaded Store Buffer with Per-Thread Write Barriers

This block holds committed stores from several hardware threads in the order they arrive and hands them to a memory issue port. Each stored entry carries a thread id, an address, a data word, a size code and a sequence number. A store that is ready is offered on the issue port. Among ready stores the oldest is offered first, and one store moves per cycle over a valid/ready handshake. Once the memory side reports a store complete, its slot is freed. Slots can be freed in any order, and the buffer still keeps the arrival age of every entry.

A thread can post a write-barrier command. The barrier attaches to that thread's youngest buffered store. While it is outstanding, new stores from that thread stay in the buffer unready. When a store that carries the barrier completes, the barrier moves back to that thread's next older buffered store, if one exists. When no older store remains, the barrier is satisfied. The thread's deferred stores then wake in age order, up to and including the next store that carries its own barrier. Per-thread counters report live entries, cumulative occupancy, cycles spent with a barrier outstanding, and barrier commands received. One further counter reports the cycles in which the buffer was full.

Events in the same cycle are applied in this order: completion, then insert, then barrier.

Top module: `store_barrier_buf`

## Requirements
- R1: An insert is accepted (`ins_accept`=1) whenever a slot is free. An accepted store is appended as the youngest entry and its thread's `ent_count` rises by one. When all slots are occupied, `ins_accept` is 0, the offered store is dropped and no state changes.
- R2: An accepted store becomes ready at once if its thread has no barrier outstanding. Otherwise it stays buffered and is not offered on the issue port.
- R3: A barrier command on a thread that has buffered stores marks that thread's youngest store and sets the thread's outstanding-barrier state.
- R4: A barrier command on a thread with no buffered stores does not hold back later stores of that thread. It still increments that thread's `bar_total`.
- R5: When a marked store completes and an older store of the same thread is still buffered, the mark moves to the nearest older such store, and the deferred stores stay unready.
- R6: When a marked store completes and no older store of its thread remains, the thread's younger deferred stores become ready in age order. The wake-up stops after the first of them that carries its own mark, and that store is also made ready.
- R7: After that wake-up, the thread's outstanding-barrier state is cleared only if no further marked store was found. Otherwise it stays set, and the stores behind the next mark remain deferred.
- R8: A completion names a slot that has already been issued. The entry is removed, and its thread's `ent_count` falls by one.
- R9: On every clock, each thread's `occ_total` adds that thread's live entry count, and `pend_cycles` adds one if that thread's barrier is outstanding. `full_cycles` adds one if every slot is occupied.
- R10: The issue port offers the oldest entry that is ready and not yet issued. It presents the thread, address, data, size code (0 byte, 1 half, 2 word, 3 double, passed through unchanged), sequence number and slot. A store is handed over when `iss_valid` and `iss_ready` are both high, and it is not offered again.
- R11: Reset empties the buffer and clears all marks, outstanding-barrier state and counters: `ins_accept`=1, `iss_valid`=0, and all counters read 0.
- R12: If an insert and a barrier command for the same thread arrive in the same cycle, the barrier attaches to the new store. That store itself is ready, and the thread's next store is deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Store insert request |
| ins_thread | input | TW | Thread of the offered store |
| ins_addr | input | AW | Store address |
| ins_data | input | DW | Store data |
| ins_size | input | 2 | Size code |
| ins_seq | input | SEQW | Sequence number |
| ins_accept | output | 1 | High when a slot is free; the insert is taken at the clock edge |
| bar_valid | input | 1 | Write-barrier command |
| bar_thread | input | TW | Thread issuing the barrier |
| iss_valid | output | 1 | A ready store is offered |
| iss_ready | input | 1 | Memory side takes the offered store |
| iss_thread | output | TW | Thread of the offered store |
| iss_addr | output | AW | Address of the offered store |
| iss_data | output | DW | Data of the offered store |
| iss_size | output | 2 | Size code of the offered store |
| iss_seq | output | SEQW | Sequence number of the offered store |
| iss_slot | output | IW | Slot index, used later to report completion |
| cmp_valid | input | 1 | Store completion report |
| cmp_slot | input | IW | Slot of the completed store |
| ent_count | output | THREADS*NW | Live entries per thread |
| occ_total | output | THREADS*CW | Cumulative occupancy per thread |
| pend_cycles | output | THREADS*CW | Cycles with a barrier outstanding, per thread |
| bar_total | output | THREADS*CW | Barrier commands received, per thread |
| full_cycles | output | CW | Cycles with every slot occupied |

## Verification
The bench builds the block with its defaults: eight slots, two threads and 8-bit sequence numbers. Two threads are enough to show that a barrier on one thread leaves the other thread's stores issuing, in oldest-first order around the deferred ones. Eight slots are few enough that the bench fills the buffer, sees a rejected insert, and then drains every entry out of order against the completion port. A nested pair of barriers on one thread shows both outcomes of the wake-up scan: it stopping at a marked store, and the outstanding state clearing.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

   // Size code carried with each store
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } sbb_size_e;

   // Index width that never collapses to zero
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sbb_age_matrix.sv
// Pairwise arrival-order record: older[i][j] is set when slot i arrived before slot j.
module sbb_age_matrix #(
   parameter int DEPTH = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ins_en,
   input  logic [DEPTH-1:0]            ins_oh,
   input  logic [DEPTH-1:0]            live,
   output logic [DEPTH-1:0][DEPTH-1:0] older
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older <= '0;
      end else if (ins_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
               if (ins_oh[j])
                  older[i][j] <= live[i] && !ins_oh[i];
               else if (ins_oh[i])
                  older[i][j] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/sbb_age_pick.sv
// Chooses the oldest or the youngest member of a candidate set.
module sbb_age_pick #(
   parameter int DEPTH      = 8,
   parameter bit PICK_YOUNG = 1'b0
) (
   input  logic [DEPTH-1:0]            cand,
   input  logic [DEPTH-1:0][DEPTH-1:0] older,
   output logic [DEPTH-1:0]            pick,
   output logic                        any
);

   generate
      if (PICK_YOUNG) begin : g_young
         always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
               logic blk;
               blk = 1'b0;
               for (int j = 0; j < DEPTH; j++)
                  blk = blk | (cand[j] & older[i][j]);
               pick[i] = cand[i] & ~blk;
            end
         end
      end else begin : g_old
         always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
               logic blk;
               blk = 1'b0;
               for (int j = 0; j < DEPTH; j++)
                  blk = blk | (cand[j] & older[j][i]);
               pick[i] = cand[i] & ~blk;
            end
         end
      end
   endgenerate

   assign any = |cand;

endmodule

// File: rtl/sbb_thread_ctr.sv
// Per-thread entry count and cumulative activity counters.
module sbb_thread_ctr #(
   parameter int NW = 4,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          bar,
   input  logic          pend,
   output logic [NW-1:0] ent,
   output logic [CW-1:0] occ,
   output logic [CW-1:0] pcyc,
   output logic [CW-1:0] bcnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent  <= '0;
         occ  <= '0;
         pcyc <= '0;
         bcnt <= '0;
      end else begin
         if (inc && !dec)
            ent <= ent + NW'(1);
         else if (dec && !inc)
            ent <= ent - NW'(1);
         occ <= occ + CW'(ent);
         if (pend)
            pcyc <= pcyc + CW'(1);
         if (bar)
            bcnt <= bcnt + CW'(1);
      end
   end

endmodule

// File: rtl/store_barrier_buf.sv
module store_barrier_buf
   import sbb_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int THREADS = 2,
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter int SEQW    = 8,
   parameter int CW      = 16,
   localparam int IW     = idx_w(DEPTH),
   localparam int TW     = idx_w(THREADS),
   localparam int NW     = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ins_valid,
   input  logic [TW-1:0]         ins_thread,
   input  logic [AW-1:0]         ins_addr,
   input  logic [DW-1:0]         ins_data,
   input  logic [1:0]            ins_size,
   input  logic [SEQW-1:0]       ins_seq,
   output logic                  ins_accept,
   input  logic                  bar_valid,
   input  logic [TW-1:0]         bar_thread,
   output logic                  iss_valid,
   input  logic                  iss_ready,
   output logic [TW-1:0]         iss_thread,
   output logic [AW-1:0]         iss_addr,
   output logic [DW-1:0]         iss_data,
   output logic [1:0]            iss_size,
   output logic [SEQW-1:0]       iss_seq,
   output logic [IW-1:0]         iss_slot,
   input  logic                  cmp_valid,
   input  logic [IW-1:0]         cmp_slot,
   output logic [THREADS*NW-1:0] ent_count,
   output logic [THREADS*CW-1:0] occ_total,
   output logic [THREADS*CW-1:0] pend_cycles,
   output logic [THREADS*CW-1:0] bar_total,
   output logic [CW-1:0]         full_cycles
);

   // elaboration-time parameter checks
   if (DEPTH < 2)        begin : g_bad_depth   $error("DEPTH must be at least 2");       end
   if (THREADS < 1)      begin : g_bad_threads $error("THREADS must be at least 1");     end
   if (SEQW < 1)         begin : g_bad_seq     $error("SEQW must be at least 1");        end
   if (CW < NW)          begin : g_bad_cw      $error("CW must hold an entry count");    end

   // entry state
   logic [DEPTH-1:0]            e_valid, e_rdy, e_iss, e_flag;
   logic [DEPTH-1:0][TW-1:0]    e_thr;
   logic [DEPTH-1:0][AW-1:0]    e_addr;
   logic [DEPTH-1:0][DW-1:0]    e_data;
   logic [DEPTH-1:0][1:0]       e_size;
   logic [DEPTH-1:0][SEQW-1:0]  e_seq;
   logic [THREADS-1:0]          pend;
   logic [DEPTH-1:0][DEPTH-1:0] older;

   logic full, ins_fire, iss_fire;
   logic [DEPTH-1:0] free_oh, cmp_oh;

   assign full       = &e_valid;
   assign ins_accept = ~full;
   assign ins_fire   = ins_valid & ~full;

   // lowest free slot
   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (!e_valid[j] && !found) begin
            free_oh[j] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   always_comb begin
      for (int j = 0; j < DEPTH; j++)
         cmp_oh[j] = cmp_valid && (cmp_slot == IW'(j));
   end

   sbb_age_matrix #(.DEPTH(DEPTH)) u_age (
      .clk    (clk),
      .rst_n  (rst_n),
      .ins_en (ins_fire),
      .ins_oh (free_oh),
      .live   (e_valid),
      .older  (older)
   );

   // ---------------- completion: barrier move or release ----------------
   logic [TW-1:0]    ct;
   logic [DEPTH-1:0] older_of_c, younger_of_c, mv_oh, wake;
   logic             c_flag, has_older, release_c, still, mv_any;

   assign ct     = e_thr[cmp_slot];
   assign c_flag = cmp_valid & e_flag[cmp_slot];

   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         logic same;
         same            = e_valid[j] && !cmp_oh[j] && (e_thr[j] == ct);
         older_of_c[j]   = same && older[j][cmp_slot];
         younger_of_c[j] = same && older[cmp_slot][j];
      end
   end

   sbb_age_pick #(.DEPTH(DEPTH), .PICK_YOUNG(1'b1)) u_nearest (
      .cand  (older_of_c),
      .older (older),
      .pick  (mv_oh),
      .any   (mv_any)
   );

   assign has_older = mv_any;
   assign release_c = c_flag & ~has_older;
   assign still     = |(younger_of_c & e_flag);

   // wake every younger same-thread store with no marked store strictly between
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         logic blk;
         blk = 1'b0;
         for (int k = 0; k < DEPTH; k++)
            blk = blk | (younger_of_c[k] & e_flag[k] & older[k][j]);
         wake[j] = release_c & younger_of_c[j] & ~blk;
      end
   end

   logic [THREADS-1:0] pend_mid, pend_nx;
   always_comb begin
      pend_mid = pend;
      if (release_c)
         pend_mid[ct] = still;
   end

   logic new_rdy;
   assign new_rdy = ~pend_mid[ins_thread];

   // ---------------- barrier command ----------------
   logic [DEPTH-1:0] bcand, by_oh, bar_oh;
   logic             by_any, bar_hit;

   always_comb begin
      for (int j = 0; j < DEPTH; j++)
         bcand[j] = e_valid[j] && !cmp_oh[j] && (e_thr[j] == bar_thread);
   end

   sbb_age_pick #(.DEPTH(DEPTH), .PICK_YOUNG(1'b1)) u_bar_pick (
      .cand  (bcand),
      .older (older),
      .pick  (by_oh),
      .any   (by_any)
   );

   always_comb begin
      if (!bar_valid)
         bar_oh = '0;
      else if (ins_fire && (ins_thread == bar_thread))
         bar_oh = free_oh;
      else
         bar_oh = by_oh;
   end
   assign bar_hit = |bar_oh;

   always_comb begin
      pend_nx = pend_mid;
      if (bar_hit)
         pend_nx[bar_thread] = 1'b1;
   end

   // ---------------- issue selection ----------------
   logic [DEPTH-1:0] icand, iss_oh;
   logic             iss_any;

   assign icand = e_valid & e_rdy & ~e_iss;

   sbb_age_pick #(.DEPTH(DEPTH), .PICK_YOUNG(1'b0)) u_iss_pick (
      .cand  (icand),
      .older (older),
      .pick  (iss_oh),
      .any   (iss_any)
   );

   always_comb begin
      iss_slot = '0;
      for (int j = 0; j < DEPTH; j++)
         if (iss_oh[j]) iss_slot = IW'(j);
   end

   assign iss_valid  = iss_any;
   assign iss_thread = e_thr[iss_slot];
   assign iss_addr   = e_addr[iss_slot];
   assign iss_data   = e_data[iss_slot];
   assign iss_size   = e_size[iss_slot];
   assign iss_seq    = e_seq[iss_slot];
   assign iss_fire   = iss_valid & iss_ready;

   // ---------------- entry update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= '0;
         e_rdy   <= '0;
         e_iss   <= '0;
         e_flag  <= '0;
         e_thr   <= '0;
         e_addr  <= '0;
         e_data  <= '0;
         e_size  <= '0;
         e_seq   <= '0;
         pend    <= '0;
      end else begin
         pend <= pend_nx;
         for (int j = 0; j < DEPTH; j++) begin
            if (cmp_oh[j]) begin
               e_valid[j] <= 1'b0;
               e_rdy[j]   <= 1'b0;
               e_iss[j]   <= 1'b0;
               e_flag[j]  <= 1'b0;
            end else if (ins_fire && free_oh[j]) begin
               e_valid[j] <= 1'b1;
               e_rdy[j]   <= new_rdy;
               e_iss[j]   <= 1'b0;
               e_flag[j]  <= bar_oh[j];
               e_thr[j]   <= ins_thread;
               e_addr[j]  <= ins_addr;
               e_data[j]  <= ins_data;
               e_size[j]  <= ins_size;
               e_seq[j]   <= ins_seq;
            end else begin
               e_rdy[j]  <= e_rdy[j] | wake[j];
               e_iss[j]  <= e_iss[j] | (iss_fire & iss_oh[j]);
               e_flag[j] <= e_flag[j] | (c_flag & mv_oh[j]) | bar_oh[j];
            end
         end
      end
   end

   // ---------------- counters ----------------
   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      sbb_thread_ctr #(.NW(NW), .CW(CW)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ins_fire && (ins_thread == TW'(t))),
         .dec   (cmp_valid && (ct == TW'(t))),
         .bar   (bar_valid && (bar_thread == TW'(t))),
         .pend  (pend[t]),
         .ent   (ent_count[t*NW +: NW]),
         .occ   (occ_total[t*CW +: CW]),
         .pcyc  (pend_cycles[t*CW +: CW]),
         .bcnt  (bar_total[t*CW +: CW])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         full_cycles <= '0;
      else if (full)
         full_cycles <= full_cycles + CW'(1);
   end

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
   parameter int DEPTH   = 8,
   parameter int THREADS = 2,
   parameter int TW      = 1,
   parameter int IW      = 3,
   parameter int NW      = 4,
   parameter int CW      = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ins_accept,
   input logic [THREADS*NW-1:0] ent_count,
   input logic                  cmp_valid,
   input logic [IW-1:0]         cmp_slot,
   input logic [DEPTH-1:0]      e_valid,
   input logic [DEPTH-1:0]      e_rdy,
   input logic [DEPTH-1:0]      e_iss,
   input logic [DEPTH-1:0]      e_flag,
   input logic [DEPTH-1:0][TW-1:0] e_thr,
   input logic [THREADS-1:0]    pend,
   input logic                  iss_valid,
   input logic [IW-1:0]         iss_slot,
   input logic [CW-1:0]         full_cycles
);

   int  total;
   logic deferred_bad, flag_bad;

   always_comb begin
      total = 0;
      for (int t = 0; t < THREADS; t++)
         total = total + int'(ent_count[t*NW +: NW]);
      deferred_bad = 1'b0;
      flag_bad     = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
         if (e_valid[j] && !e_rdy[j] && !pend[e_thr[j]]) deferred_bad = 1'b1;
         if (e_valid[j] && e_flag[j] && !pend[e_thr[j]]) flag_bad = 1'b1;
      end
   end

   // R1
   accept_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_accept == (total < DEPTH));

   // R2
   no_orphan_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !deferred_bad);

   // R3
   mark_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_bad);

   // R8
   cmp_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> (e_valid[cmp_slot] && e_iss[cmp_slot]));

   // R10
   offer_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (e_valid[iss_slot] && e_rdy[iss_slot] && !e_iss[iss_slot]));

   // R9
   full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_accept |=> full_cycles == CW'($past(full_cycles) + CW'(1)));

endmodule

bind store_barrier_buf sbb_checker #(
   .DEPTH(DEPTH), .THREADS(THREADS), .TW(TW), .IW(IW), .NW(NW), .CW(CW)
) u_sbb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ins_accept  (ins_accept),
   .ent_count   (ent_count),
   .cmp_valid   (cmp_valid),
   .cmp_slot    (cmp_slot),
   .e_valid     (e_valid),
   .e_rdy       (e_rdy),
   .e_iss       (e_iss),
   .e_flag      (e_flag),
   .e_thr       (e_thr),
   .pend        (pend),
   .iss_valid   (iss_valid),
   .iss_slot    (iss_slot),
   .full_cycles (full_cycles)
);

// File: tb/test_store_barrier_buf.sv
module test_store_barrier_buf;

   localparam int DEPTH = 8, THREADS = 2, AW = 16, DW = 32, SEQW = 8, CW = 16;
   localparam int IW = 3, TW = 1, NW = 4;

   // row: kind[12:10] thread[9] seq[8:1] exp[0]
   // kinds: 0 insert, 1 barrier, 2 issue, 3 nothing offered, 4 complete, 5 insert+barrier
   localparam int N = 39;
   localparam logic [12:0] VEC [0:N-1] = '{
      {3'd0,1'b0,8'd1,1'b1},  {3'd0,1'b0,8'd2,1'b1},  {3'd1,1'b0,8'd0,1'b0},   // R3 mark on seq 2
      {3'd0,1'b0,8'd3,1'b1},  {3'd0,1'b1,8'd10,1'b1},                         // seq 3 deferred
      {3'd2,1'b0,8'd1,1'b0},  {3'd2,1'b0,8'd2,1'b0},  {3'd2,1'b1,8'd10,1'b0},  // other thread flows
      {3'd3,1'b0,8'd0,1'b0},                                                   // R2 seq 3 held
      {3'd4,1'b0,8'd2,1'b0},  {3'd3,1'b0,8'd0,1'b0},                           // R5 mark moves to seq 1
      {3'd4,1'b0,8'd1,1'b0},  {3'd2,1'b0,8'd3,1'b0},                           // R6 release wakes seq 3
      {3'd4,1'b0,8'd3,1'b0},  {3'd4,1'b1,8'd10,1'b0},
      {3'd1,1'b1,8'd0,1'b0},  {3'd0,1'b1,8'd30,1'b1}, {3'd2,1'b1,8'd30,1'b0},  // R4 empty barrier
      {3'd4,1'b1,8'd30,1'b0},
      {3'd0,1'b0,8'd20,1'b1}, {3'd1,1'b0,8'd0,1'b0},  {3'd0,1'b0,8'd21,1'b1},  // nested marks
      {3'd1,1'b0,8'd0,1'b0},  {3'd0,1'b0,8'd22,1'b1},
      {3'd2,1'b0,8'd20,1'b0}, {3'd3,1'b0,8'd0,1'b0},  {3'd4,1'b0,8'd20,1'b0},
      {3'd2,1'b0,8'd21,1'b0}, {3'd3,1'b0,8'd0,1'b0},                           // R6 stop at marked 21, R7 still held
      {3'd4,1'b0,8'd21,1'b0}, {3'd2,1'b0,8'd22,1'b0}, {3'd4,1'b0,8'd22,1'b0},  // R7 cleared
      {3'd5,1'b1,8'd50,1'b1}, {3'd0,1'b1,8'd51,1'b1}, {3'd2,1'b1,8'd50,1'b0},  // R12 same-cycle pair
      {3'd3,1'b0,8'd0,1'b0},  {3'd4,1'b1,8'd50,1'b0}, {3'd2,1'b1,8'd51,1'b0},
      {3'd4,1'b1,8'd51,1'b0}
   };

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  ins_valid, ins_accept, bar_valid, iss_valid, iss_ready, cmp_valid;
   logic [TW-1:0]         ins_thread, bar_thread, iss_thread;
   logic [AW-1:0]         ins_addr, iss_addr;
   logic [DW-1:0]         ins_data, iss_data;
   logic [1:0]            ins_size, iss_size;
   logic [SEQW-1:0]       ins_seq, iss_seq;
   logic [IW-1:0]         iss_slot, cmp_slot;
   logic [THREADS*NW-1:0] ent_count;
   logic [THREADS*CW-1:0] occ_total, pend_cycles, bar_total;
   logic [CW-1:0]         full_cycles;

   int checks = 0, fails = 0;
   logic [IW-1:0] slot_of [0:255];

   always #10 clk = ~clk;

   store_barrier_buf #(.DEPTH(DEPTH), .THREADS(THREADS), .AW(AW), .DW(DW),
                       .SEQW(SEQW), .CW(CW)) i_store_barrier_buf (.*);

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      ins_valid = 0; ins_thread = 0; ins_addr = 0; ins_data = 0; ins_size = 0; ins_seq = 0;
      bar_valid = 0; bar_thread = 0; iss_ready = 0; cmp_valid = 0; cmp_slot = 0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 0;
      step(); step();
      rst_n = 1;
   endtask

   task automatic drive_ins(input logic t, input logic [7:0] s);
      ins_valid = 1; ins_thread = t; ins_seq = s;
      ins_addr = AW'({s, 2'b00}); ins_data = {4{s}}; ins_size = s[1:0];
   endtask

   task automatic do_issue(input logic [7:0] s, input logic t);
      chk(iss_valid === 1'b1, "R10 offer present", int'(iss_valid), 1);
      chk(iss_seq === s && iss_thread === t && iss_addr === AW'({s, 2'b00})
          && iss_data === {4{s}} && iss_size === s[1:0], "R10 oldest ready store",
          int'(iss_seq), int'(s));
      slot_of[iss_seq] = iss_slot;
      iss_ready = 1;
      step();
      iss_ready = 0;
   endtask

   task automatic do_cmp(input logic [7:0] s);
      cmp_valid = 1; cmp_slot = slot_of[s];
      step();
      cmp_valid = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R11 reset state
      chk(ins_accept === 1'b1 && iss_valid === 1'b0, "R11 idle after reset",
          int'(iss_valid), 0);
      chk(ent_count === '0 && occ_total === '0 && bar_total === '0 && full_cycles === '0,
          "R11 counters cleared", int'(ent_count), 0);

      // table walk
      for (int r = 0; r < N; r++) begin
         logic [2:0] k;
         logic       t;
         logic [7:0] s;
         logic       e;
         {k, t, s, e} = VEC[r];
         case (k)
            3'd0: begin
               drive_ins(t, s);
               chk(ins_accept === e, "R1 insert accepted", int'(ins_accept), int'(e));
               step();
               idle_inputs();
            end
            3'd1: begin
               bar_valid = 1; bar_thread = t;
               step();
               idle_inputs();
            end
            3'd2: do_issue(s, t);
            3'd3: begin
               chk(iss_valid === 1'b0, "R2 deferred store not offered", int'(iss_valid), 0);
               step();
            end
            3'd4: do_cmp(s);
            default: begin
               drive_ins(t, s);
               bar_valid = 1; bar_thread = t;
               chk(ins_accept === 1'b1, "R12 insert with barrier", int'(ins_accept), 1);
               step();
               idle_inputs();
            end
         endcase
      end

      // R1 fill, reject when full
      for (int i = 0; i < DEPTH; i++) begin
         drive_ins(1'b1, 8'(40 + i));
         step();
         idle_inputs();
      end
      drive_ins(1'b1, 8'd48);
      chk(ins_accept === 1'b0, "R1 full rejects", int'(ins_accept), 0);
      step();
      idle_inputs();
      chk(ent_count[NW +: NW] === NW'(DEPTH), "R1 count unchanged by reject",
          int'(ent_count[NW +: NW]), DEPTH);
      for (int i = 0; i < DEPTH; i++) do_issue(8'(40 + i), 1'b1);
      chk(iss_valid === 1'b0, "R1 rejected store absent", int'(iss_valid), 0);
      // R8 out-of-order completion empties the thread
      for (int i = DEPTH - 1; i >= 0; i--) do_cmp(8'(40 + i));
      chk(ent_count[NW +: NW] === '0, "R8 entries removed", int'(ent_count[NW +: NW]), 0);
      chk(ins_accept === 1'b1, "R8 slots freed", int'(ins_accept), 1);

      // R9 counters from a fresh reset
      do_reset();
      drive_ins(1'b0, 8'd1);
      step();
      idle_inputs();
      repeat (4) step();
      chk(occ_total[0 +: CW] === CW'(4), "R9 occupancy", int'(occ_total[0 +: CW]), 4);
      chk(ent_count[0 +: NW] === NW'(1), "R1 entry count", int'(ent_count[0 +: NW]), 1);
      bar_valid = 1; bar_thread = 0;
      step();
      idle_inputs();
      repeat (3) step();
      chk(pend_cycles[0 +: CW] === CW'(3), "R3 R9 pending cycles", int'(pend_cycles[0 +: CW]), 3);
      chk(occ_total[0 +: CW] === CW'(8), "R9 occupancy running", int'(occ_total[0 +: CW]), 8);
      chk(bar_total[0 +: CW] === CW'(1), "R9 barrier total", int'(bar_total[0 +: CW]), 1);
      bar_valid = 1; bar_thread = 1;
      step();
      idle_inputs();
      step(); step();
      chk(bar_total[CW +: CW] === CW'(1), "R4 empty barrier counted", int'(bar_total[CW +: CW]), 1);
      chk(pend_cycles[CW +: CW] === '0, "R4 empty barrier not pending",
          int'(pend_cycles[CW +: CW]), 0);
      for (int i = 0; i < DEPTH - 1; i++) begin
         drive_ins(1'b1, 8'(60 + i));
         step();
         idle_inputs();
      end
      repeat (5) step();
      chk(full_cycles === CW'(5), "R9 full cycles", int'(full_cycles), 5);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule